// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer Controller

This block tracks the receive buffers of a single USB device OUT endpoint. It can run with one buffer or with two buffers used in ping-pong order. The protocol engine sends it one-cycle event pulses:

- the start of an OUT token;
- the end of a received packet, together with the packet's byte count;
- bit-stuffing and CRC error indications for that packet.

Software, or the FIFO reader, tells the block when a buffer has been drained. The block then keeps four pieces of state:

- a two-bit occupancy code;
- which buffer the next packet fills;
- which buffer is read next;
- three sticky error flags: overrun, forced stall and data error.

From that state it decides whether reception is possible, and whether a bulk transaction must be answered with NAK or STALL.

Software clears each error flag by writing a one to that flag's own clear input. A flush input empties both buffers at once. With automatic release enabled, the FIFO reader's end-of-buffer pulse frees the buffer, and no software write is needed. The transfer type input selects between bulk and isochronous behaviour.

Top module: `usb_out_bufctl`

## Requirements
- R1: `occ_sts` reads 00 when no buffer holds data. With two buffers, 10 means one is full and 11 means both are full. With one buffer, 11 means full and 10 never appears. The code 01 never appears.
- R2: `occ_sts`, `wr_buf` and `rd_buf` change only in the cycle after an accepted packet, a buffer release or a flush. A token, a rejected packet or a flag-clear write leaves them unchanged.
- R3: An `rx_done` pulse stores a packet only when all of these hold: `rx_en` is high, `rx_len` is at most `max_pkt`, and neither `stuff_err` nor `crc_err` is asserted. With two buffers, `wr_buf` toggles (0 then 1) on each stored packet and `rd_buf` toggles on each release. With one buffer, both stay 0.
- R4: A release frees one buffer. When `auto_rel`=0 the release comes from `sw_release`. When `auto_rel`=1 it comes from `rd_last`, and `sw_release` has no effect. A release while no buffer holds data is ignored.
- R5: A packet with `rx_len` > `max_pkt` sets `stall_flag`. While `stall_flag` is high, `rx_en` is low and nothing is stored. In bulk mode (`iso_mode`=0), `hs_stall` follows `stall_flag`.
- R6: In isochronous mode, `tok_start` sets `ovr_flag` when at least one buffer holds data and `rx_en` is low. In bulk mode `ovr_flag` never sets.
- R7: In isochronous mode, an `rx_done` pulse with `stuff_err` or `crc_err` sets `derr_flag`. In bulk mode `derr_flag` never sets.
- R8: Each flag clears only through its own clear input (`clr_ovr`, `clr_stall`, `clr_derr`). A set event in the same cycle as the clear leaves the flag set.
- R9: `sw_flush` empties both buffers, returns `occ_sts` to 00 and sets `wr_buf` and `rd_buf` to 0. It takes priority over a packet or release in the same cycle, and it leaves the flags unchanged.
- R10: If a packet is stored and a buffer is released in the same cycle, the occupancy stays the same and both buffer pointers advance.
- R11: `rx_en` is high exactly when a free buffer exists and `stall_flag` is low. `hs_nak` is high in bulk mode when `stall_flag` is low and no buffer is free. `hs_nak` and `hs_stall` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_mode | input | 1 | 1 = two buffers, 0 = one buffer |
| iso_mode | input | 1 | 1 = isochronous, 0 = bulk |
| auto_rel | input | 1 | 1 = release on `rd_last` instead of `sw_release` |
| max_pkt | input | LEN_W | Largest allowed packet length in bytes |
| tok_start | input | 1 | Pulse at the start of an OUT token |
| rx_done | input | 1 | Pulse at the end of a received packet |
| rx_len | input | LEN_W | Byte count of the packet, valid with `rx_done` |
| stuff_err | input | 1 | Bit-stuffing error, valid with `rx_done` |
| crc_err | input | 1 | CRC error, valid with `rx_done` |
| rd_last | input | 1 | Pulse when the reader has drained one buffer |
| sw_release | input | 1 | Software buffer-done write |
| sw_flush | input | 1 | Software flush write |
| clr_ovr | input | 1 | Write-one-to-clear for `ovr_flag` |
| clr_stall | input | 1 | Write-one-to-clear for `stall_flag` |
| clr_derr | input | 1 | Write-one-to-clear for `derr_flag` |
| occ_sts | output | 2 | Occupancy code |
| wr_buf | output | 1 | Buffer the next stored packet goes to |
| rd_buf | output | 1 | Buffer the reader consumes next |
| ovr_flag | output | 1 | Sticky isochronous overrun |
| stall_flag | output | 1 | Sticky oversize-packet stall |
| derr_flag | output | 1 | Sticky isochronous data error |
| rx_en | output | 1 | Reception possible |
| hs_stall | output | 1 | Answer bulk packet with STALL |
| hs_nak | output | 1 | Answer bulk packet with NAK |

## Verification
The hardest case to reach from the ports is a stored packet and a release landing in the same cycle while exactly one of two buffers is full. The occupancy code must not move, yet both pointers must advance. A related hard case is a set event racing its own clear write. The bench drives these cases on purpose, then sweeps all eight combinations of buffer count, transfer type and release source with randomly mixed pulses. In that sweep oversize and erroneous packets are kept rare, so the buffers actually fill, and full buffers meet tokens often enough to raise overrun.

// File: rtl/usb_out_bufctl.sv
module usb_out_bufctl #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl_mode,
  input  logic             iso_mode,
  input  logic             auto_rel,
  input  logic [LEN_W-1:0] max_pkt,
  input  logic             tok_start,
  input  logic             rx_done,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             stuff_err,
  input  logic             crc_err,
  input  logic             rd_last,
  input  logic             sw_release,
  input  logic             sw_flush,
  input  logic             clr_ovr,
  input  logic             clr_stall,
  input  logic             clr_derr,
  output logic [1:0]       occ_sts,
  output logic             wr_buf,
  output logic             rd_buf,
  output logic             ovr_flag,
  output logic             stall_flag,
  output logic             derr_flag,
  output logic             rx_en,
  output logic             hs_stall,
  output logic             hs_nak
);

  logic [1:0] cnt;
  logic       free, len_ok, accept, rel_req, release_ok;
  logic       ovr_set, stall_set, derr_set;

  assign free       = dbl_mode ? (cnt != 2'd2) : (cnt == 2'd0);
  assign rx_en      = free && !stall_flag;
  assign len_ok     = rx_len <= max_pkt;
  assign accept     = rx_done && rx_en && len_ok && !stuff_err && !crc_err;
  assign rel_req    = auto_rel ? rd_last : sw_release;
  assign release_ok = rel_req && (cnt != 2'd0);

  assign ovr_set    = iso_mode && tok_start && (cnt != 2'd0) && !rx_en;
  assign stall_set  = rx_done && !len_ok;
  assign derr_set   = iso_mode && rx_done && (stuff_err || crc_err);

  assign hs_stall   = !iso_mode && stall_flag;
  assign hs_nak     = !iso_mode && !stall_flag && !free;

  always_comb begin
    if (cnt == 2'd0)   occ_sts = 2'b00;
    else if (dbl_mode) occ_sts = (cnt == 2'd2) ? 2'b11 : 2'b10;
    else               occ_sts = 2'b11;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= 2'd0;
      wr_buf <= 1'b0;
      rd_buf <= 1'b0;
    end else if (sw_flush) begin
      cnt    <= 2'd0;
      wr_buf <= 1'b0;
      rd_buf <= 1'b0;
    end else begin
      cnt <= 2'(cnt + {1'b0, accept} - {1'b0, release_ok});
      if (dbl_mode && accept)     wr_buf <= !wr_buf;
      if (dbl_mode && release_ok) rd_buf <= !rd_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_flag   <= 1'b0;
      stall_flag <= 1'b0;
      derr_flag  <= 1'b0;
    end else begin
      ovr_flag   <= ovr_set   || (ovr_flag   && !clr_ovr);
      stall_flag <= stall_set || (stall_flag && !clr_stall);
      derr_flag  <= derr_set  || (derr_flag  && !clr_derr);
    end
  end

  a_r1_no_code01: assert property (@(posedge clk) disable iff (!rst_n)
    occ_sts != 2'b01);
  a_r1_single_no10: assert property (@(posedge clk) disable iff (!rst_n)
    !dbl_mode |-> occ_sts != 2'b10);
  a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_done && !rd_last && !sw_release && !sw_flush) |=>
      (occ_sts == $past(occ_sts) || dbl_mode != $past(dbl_mode)));
  a_r5_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall_flag |-> !rx_en);
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_ovr) |=> ovr_flag);
  a_r8_stall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_flag && !clr_stall) |=> stall_flag);
  a_r8_derr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (derr_flag && !clr_derr) |=> derr_flag);
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    sw_flush |=> (occ_sts == 2'b00 && !wr_buf && !rd_buf));
  a_r11_hs_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_stall && hs_nak));

endmodule

// File: tb/usb_out_bufctl_tb.sv
`timescale 1ns/1ps
module usb_out_bufctl_tb;
  localparam int LEN_W = 11;

  logic clk = 0, rst_n = 0;
  logic dbl_mode = 0, iso_mode = 0, auto_rel = 0;
  logic [LEN_W-1:0] max_pkt = 11'd8, rx_len = '0;
  logic tok_start = 0, rx_done = 0, stuff_err = 0, crc_err = 0, rd_last = 0;
  logic sw_release = 0, sw_flush = 0, clr_ovr = 0, clr_stall = 0, clr_derr = 0;
  logic [1:0] occ_sts;
  logic wr_buf, rd_buf, ovr_flag, stall_flag, derr_flag, rx_en, hs_stall, hs_nak;

  int n_chk = 0, n_bad = 0;
  int m_cnt;
  logic m_wp, m_rp, m_ovr, m_st, m_de;

  always #2 clk = ~clk;

  usb_out_bufctl #(.LEN_W(LEN_W)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic m_free();
    return dbl_mode ? (m_cnt < 2) : (m_cnt == 0);
  endfunction

  function automatic int m_sts();
    if (m_cnt == 0) return 0;
    if (dbl_mode) return (m_cnt == 2) ? 3 : 2;
    return 3;
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_wp = 0; m_rp = 0; m_ovr = 0; m_st = 0; m_de = 0;
  endtask

  task automatic compare_all();
    chk("R1 occ_sts", occ_sts, m_sts());
    chk("R3 wr_buf", wr_buf, m_wp);
    chk("R3 rd_buf", rd_buf, m_rp);
    chk("R6 ovr_flag", ovr_flag, m_ovr);
    chk("R5 stall_flag", stall_flag, m_st);
    chk("R7 derr_flag", derr_flag, m_de);
    chk("R11 rx_en", rx_en, m_free() && !m_st);
    chk("R5 hs_stall", hs_stall, !iso_mode && m_st);
    chk("R11 hs_nak", hs_nak, !iso_mode && !m_st && !m_free());
  endtask

  task automatic cycle();
    logic en, acc, rel, lok;
    en  = m_free() && !m_st;
    lok = rx_len <= max_pkt;
    acc = rx_done && en && lok && !stuff_err && !crc_err;
    rel = (auto_rel ? rd_last : sw_release) && m_cnt != 0;
    if (sw_flush) begin m_cnt = 0; m_wp = 0; m_rp = 0; end
    else begin
      m_cnt = m_cnt + int'(acc) - int'(rel);
      if (dbl_mode && acc) m_wp = !m_wp;
      if (dbl_mode && rel) m_rp = !m_rp;
    end
    m_ovr = (iso_mode && tok_start && !en && (m_cnt_before_nonzero(acc, rel))) || (m_ovr && !clr_ovr);
    m_st  = (rx_done && !lok) || (m_st && !clr_stall);
    m_de  = (iso_mode && rx_done && (stuff_err || crc_err)) || (m_de && !clr_derr);
    @(posedge clk);
    @(negedge clk);
    {tok_start, rx_done, stuff_err, crc_err, rd_last, sw_release, sw_flush} = '0;
    {clr_ovr, clr_stall, clr_derr} = '0;
    compare_all();
  endtask

  logic pre_nonzero;
  function automatic logic m_cnt_before_nonzero(logic a, logic r);
    return pre_nonzero;
  endfunction

  task automatic step();
    pre_nonzero = (m_cnt != 0);
    cycle();
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_reset();
  endtask

  task automatic pkt(int len);
    rx_done = 1; rx_len = LEN_W'(len);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    dbl_mode = 1; iso_mode = 0; auto_rel = 0;
    do_reset();
    compare_all();
    chk("R1 reset occ_sts", occ_sts, 0);

    pkt(4); step();
    chk("R3 first packet goes to buffer 0, next is 1", wr_buf, 1);
    chk("R1 double one full", occ_sts, 2);
    pkt(8); step();
    chk("R1 double both full", occ_sts, 3);
    chk("R11 nak when full", hs_nak, 1);
    pkt(2); sw_release = 1; step();
    chk("R10 full: packet dropped, release taken", occ_sts, 2);
    pkt(3); sw_release = 1; step();
    chk("R10 same-cycle store and release keeps occupancy", occ_sts, 2);
    chk("R10 rd_buf advanced", rd_buf, 0);
    tok_start = 1; clr_ovr = 1; clr_derr = 1; step();
    chk("R2 token and clears leave status", occ_sts, 2);

    auto_rel = 1; sw_release = 1; step();
    chk("R4 sw_release ignored in auto mode", occ_sts, 2);
    rd_last = 1; step();
    chk("R4 rd_last releases in auto mode", occ_sts, 0);
    auto_rel = 0;

    pkt(1); step();
    pkt(1); sw_flush = 1; step();
    chk("R9 flush wins over packet", occ_sts, 0);
    chk("R9 wr_buf back to 0", wr_buf, 0);

    pkt(20); clr_stall = 1; step();
    chk("R8 set wins over same-cycle clear", stall_flag, 1);
    chk("R5 bulk stall handshake", hs_stall, 1);
    pkt(2); step();
    chk("R5 no store while stalled", occ_sts, 0);
    clr_stall = 1; step();
    chk("R8 clear by write-one", stall_flag, 0);

    for (int mode = 0; mode < 8; mode++) begin
      dbl_mode = mode[0]; iso_mode = mode[1]; auto_rel = mode[2];
      do_reset();
      compare_all();
      for (int i = 0; i < 1500; i++) begin
        logic [31:0] r;
        r = $urandom;
        rx_done    = (r[1:0] == 2'd0);
        rx_len     = (r[6:2] == 5'd0) ? LEN_W'(9 + r[9:7]) : LEN_W'(r[9:7]);
        stuff_err  = (r[13:10] == 4'd0);
        crc_err    = (r[17:14] == 4'd0);
        tok_start  = r[18];
        rd_last    = (r[21:19] == 3'd0);
        sw_release = (r[24:22] == 3'd0);
        sw_flush   = (r[28:25] == 4'd0) && r[29];
        clr_ovr    = (r[31:29] == 3'd0);
        clr_stall  = (r[31:30] == 2'd0) && r[0];
        clr_derr   = (r[27:25] == 3'd1);
        step();
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule